// File: doc/BRIEF.md
# Asynchronous Strobe Register Bus Bridge

This block sits between an asynchronous, memory-style parallel bus and a clocked register file inside the chip. The bus side has active-low chip select, write strobe and output enable, a 17-bit address, and an 8-bit data path. The data path is split into an input word, an output word and an output-enable, and the pad drivers at chip level join them. All bus inputs are resampled by a fast system clock through two-flop synchronizers. A state machine then decodes read and write cycles from the resampled strobes.

The machine has five states: `ST_IDLE`, `ST_READ`, `ST_WRITE`, `ST_RECOVER` and `ST_REJECT`. Its transitions are:
- IDLE→WRITE when select and write are both asserted, whichever came last.
- IDLE→READ when select and output enable are asserted with write negated.
- READ→WRITE when the write strobe falls during a read.
- READ→IDLE when select or output enable is released.
- WRITE→RECOVER at the first release of select or write. The commit is issued here.
- RECOVER→IDLE after `REC_CYCLES` cycles with the write strobe negated.
- RECOVER→REJECT when a new cycle starts too early. The recovery error is raised here.
- REJECT→RECOVER once that cycle is withdrawn.

Writes reach the register file as a one-cycle strobe with address and data. Reads issue a one-cycle request and accept the returned word on the following cycle. A power-good input gates every commit. After it rises, it must stay high for `QUAL_CYCLES` clocks before any write is allowed through. The default is 200 ms at 250 MHz.

Top module: `strobe_bus_bridge`

## Requirements
- R1: While select and output enable are low and the write strobe is high, the bridge requests the latched address. The returned word then appears on `bus_dout` with `bus_dout_en` high.
- R2: If the address changes during a read, a new request is issued and the output follows the new address's contents.
- R3: A write produces exactly one `reg_wr_en` pulse after the first rising edge of select or write. The pulse carries the data last sampled while both strobes were low.
- R4: A write starts only once both select and write are low, in either order. A write strobe pulse with select high commits nothing.
- R5: If the write strobe falls while data is being driven, `bus_dout_en` drops within four clock cycles.
- R6: A cycle that starts before the write strobe has been high for `REC_CYCLES` cycles after a write is ignored, and `err_recovery` is set. The flag is sticky until reset.
- R7: While power-good is low, no `reg_wr_en` pulse is produced and register contents stay unchanged.
- R8: After power-good rises, writes stay blocked until it has been high for `QUAL_CYCLES` cycles. After that, writes commit normally.
- R9: An address change during a write sets the sticky `err_addr_change` flag. The write still commits to the address latched at the start of the cycle.
- R10: After reset, `reg_wr_en`, `reg_rd_req`, `bus_dout_en`, `err_recovery` and `err_addr_change` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ce_n | input | 1 | Bus chip select, active low |
| bus_we_n | input | 1 | Bus write strobe, active low |
| bus_oe_n | input | 1 | Bus output enable, active low |
| bus_addr | input | ADDR_W | Bus address |
| bus_din | input | DATA_W | Data from the bus pads |
| bus_dout | output | DATA_W | Data toward the bus pads |
| bus_dout_en | output | 1 | Pad driver enable |
| pwr_good | input | 1 | Digital supply-good indication |
| reg_wr_en | output | 1 | One-cycle write strobe to the register file |
| reg_wr_addr | output | ADDR_W | Write address |
| reg_wr_data | output | DATA_W | Write data |
| reg_rd_req | output | 1 | One-cycle read request |
| reg_rd_addr | output | ADDR_W | Read address |
| reg_rd_data | input | DATA_W | Read data, valid the cycle after the request |
| err_recovery | output | 1 | Sticky: a cycle started inside the recovery window |
| err_addr_change | output | 1 | Sticky: the address moved during a write |

## Verification
The hardest states to reach from the ports are REJECT and a read that turns into a write. The bench reaches REJECT by ending a write with the write strobe, holding it high for only two clocks, and pulling it low again while select is still held. The rejected write must leave no pulse and no memory change. For the read-to-write case, the bench drops the write strobe in the middle of a driven read. It checks that the driver enable falls and that the resulting write stores the value the bench supplied.

// File: rtl/sbb_pkg.sv
package sbb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_READ    = 3'd1,
        ST_WRITE   = 3'd2,
        ST_RECOVER = 3'd3,
        ST_REJECT  = 3'd4
    } bus_state_t;

endpackage

// File: rtl/sbb_sync.sv
module sbb_sync #(
    parameter int                 WIDTH   = 1,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/sbb_pwr_qual.sv
module sbb_pwr_qual #(
    parameter int unsigned QUAL_CYCLES = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pg_s,
    output logic pwr_ok
);

    localparam int              CW    = $clog2(QUAL_CYCLES + 1);
    localparam logic [CW-1:0]   LIMIT = CW'(QUAL_CYCLES);

    logic [CW-1:0] cnt;

    // Any low sample restarts the qualification window.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (!pg_s)        cnt <= '0;
        else if (cnt != LIMIT) cnt <= cnt + 1'b1;
    end

    assign pwr_ok = (cnt == LIMIT);

    a_r8_drop_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_s |=> !pwr_ok);

    a_r8_rise_needs_good: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_ok) |-> $past(pg_s));

endmodule

// File: rtl/sbb_cycle_fsm.sv
module sbb_cycle_fsm
    import sbb_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int DATA_W     = 8,
    parameter int REC_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,        // synchronized, active high
    input  logic              we,        // synchronized, active high
    input  logic              oe,        // synchronized, active high
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] data_s,
    input  logic              pwr_ok,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_active,
    output logic              rec_err,
    output logic              proto_err
);

    localparam int               RCW      = $clog2(REC_CYCLES + 1);
    localparam logic [RCW-1:0]   REC_LAST = RCW'(REC_CYCLES - 1);

    bus_state_t          state, state_n;
    logic [RCW-1:0]      rec_cnt;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   data_q;

    logic wr_pair, rd_pair, any_cycle;
    assign wr_pair   = ce && we;
    assign rd_pair   = ce && oe && !we;
    assign any_cycle = ce && (we || oe);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Transitions
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: begin
                if (wr_pair)      state_n = ST_WRITE;
                else if (rd_pair) state_n = ST_READ;
            end
            ST_READ: begin
                if (wr_pair)       state_n = ST_WRITE;
                else if (!rd_pair) state_n = ST_IDLE;
            end
            ST_WRITE: begin
                if (!wr_pair) state_n = ST_RECOVER;
            end
            ST_RECOVER: begin
                if (any_cycle)                        state_n = ST_REJECT;
                else if (!we && rec_cnt == REC_LAST)  state_n = ST_IDLE;
            end
            ST_REJECT: begin
                if (!any_cycle) state_n = ST_RECOVER;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en     <= 1'b0;
            rd_req    <= 1'b0;
            rd_active <= 1'b0;
            rec_err   <= 1'b0;
            proto_err <= 1'b0;
            rec_cnt   <= '0;
            addr_q    <= '0;
            data_q    <= '0;
        end else begin
            wr_en     <= 1'b0;
            rd_req    <= 1'b0;
            rd_active <= (state_n == ST_READ);

            if (state == ST_RECOVER && !we) rec_cnt <= rec_cnt + 1'b1;
            else                            rec_cnt <= '0;

            if (state_n == ST_WRITE) begin
                if (state != ST_WRITE)     addr_q    <= addr_s;
                else if (addr_s != addr_q) proto_err <= 1'b1;
                data_q <= data_s;
            end

            if (state == ST_WRITE && state_n == ST_RECOVER)
                wr_en <= pwr_ok;

            if (state_n == ST_READ && (state != ST_READ || addr_s != addr_q)) begin
                addr_q <= addr_s;
                rd_req <= 1'b1;
            end

            if (state == ST_RECOVER && state_n == ST_REJECT)
                rec_err <= 1'b1;
        end
    end

    assign wr_addr = addr_q;
    assign wr_data = data_q;
    assign rd_addr = addr_q;

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    a_r5_we_releases_read: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ && we) |=> !rd_active);

    a_r6_flag_from_recover: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rec_err) |-> $past(state == ST_RECOVER));

    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

    a_r4_write_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_WRITE && !(ce && we)) |=> state != ST_WRITE);

endmodule

// File: rtl/strobe_bus_bridge.sv
module strobe_bus_bridge #(
    parameter int          ADDR_W      = 17,
    parameter int          DATA_W      = 8,
    parameter int          SYNC_STAGES = 2,
    parameter int          REC_CYCLES  = 4,
    parameter int unsigned QUAL_CYCLES = 50_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_ce_n,
    input  logic              bus_we_n,
    input  logic              bus_oe_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_dout_en,
    input  logic              pwr_good,
    output logic              reg_wr_en,
    output logic [ADDR_W-1:0] reg_wr_addr,
    output logic [DATA_W-1:0] reg_wr_data,
    output logic              reg_rd_req,
    output logic [ADDR_W-1:0] reg_rd_addr,
    input  logic [DATA_W-1:0] reg_rd_data,
    output logic              err_recovery,
    output logic              err_addr_change
);

    localparam int AD_W = ADDR_W + DATA_W;

    logic [2:0]        strb_s;
    logic [AD_W-1:0]   ad_s;
    logic              pg_s;
    logic              pwr_ok;
    logic              rd_active;
    logic              rd_ret;
    logic              have_data;
    logic [DATA_W-1:0] dout_q;

    sbb_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync_strb (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({bus_ce_n, bus_we_n, bus_oe_n}),
        .q     (strb_s)
    );

    sbb_sync #(.WIDTH(AD_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_ad (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({bus_addr, bus_din}),
        .q     (ad_s)
    );

    sbb_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_pg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pwr_good),
        .q     (pg_s)
    );

    sbb_pwr_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .pg_s   (pg_s),
        .pwr_ok (pwr_ok)
    );

    sbb_cycle_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REC_CYCLES(REC_CYCLES)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce        (~strb_s[2]),
        .we        (~strb_s[1]),
        .oe        (~strb_s[0]),
        .addr_s    (ad_s[AD_W-1:DATA_W]),
        .data_s    (ad_s[DATA_W-1:0]),
        .pwr_ok    (pwr_ok),
        .wr_en     (reg_wr_en),
        .wr_addr   (reg_wr_addr),
        .wr_data   (reg_wr_data),
        .rd_req    (reg_rd_req),
        .rd_addr   (reg_rd_addr),
        .rd_active (rd_active),
        .rec_err   (err_recovery),
        .proto_err (err_addr_change)
    );

    // Read return: data arrives the cycle after the request.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ret    <= 1'b0;
            have_data <= 1'b0;
            dout_q    <= '0;
        end else begin
            rd_ret <= reg_rd_req;
            if (reg_rd_req || !rd_active) begin
                have_data <= 1'b0;
            end else if (rd_ret) begin
                have_data <= 1'b1;
                dout_q    <= reg_rd_data;
            end
        end
    end

    assign bus_dout    = dout_q;
    assign bus_dout_en = have_data && rd_active && !reg_rd_req;

    a_r7_commit_gated: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> $past(pwr_ok));

    a_r1_return_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ret && !reg_rd_req && rd_active) |=> (bus_dout_en || !rd_active || reg_rd_req));

endmodule

// File: tb/strobe_bus_bridge_test.sv
module strobe_bus_bridge_test;

    localparam int AW   = 17;
    localparam int DW   = 8;
    localparam int REC  = 4;
    localparam int QUAL = 40;

    // {is_write, address, data}
    localparam logic [25:0] VEC [8] = '{
        {1'b1, 17'd3,  8'hA5},
        {1'b1, 17'd5,  8'h3C},
        {1'b1, 17'd12, 8'hF0},
        {1'b1, 17'd15, 8'h81},
        {1'b0, 17'd5,  8'h3C},
        {1'b0, 17'd3,  8'hA5},
        {1'b0, 17'd15, 8'h81},
        {1'b0, 17'd12, 8'hF0}
    };

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n;
    logic          ce_n, we_n, oe_n, pwr_good;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_din, bus_dout, wr_data, rd_data;
    logic          bus_dout_en, wr_en, rd_req, err_rec, err_addr;
    logic [AW-1:0] wr_addr, rd_addr;

    strobe_bus_bridge #(
        .ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2),
        .REC_CYCLES(REC), .QUAL_CYCLES(QUAL)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .bus_ce_n(ce_n), .bus_we_n(we_n), .bus_oe_n(oe_n),
        .bus_addr(bus_addr), .bus_din(bus_din),
        .bus_dout(bus_dout), .bus_dout_en(bus_dout_en),
        .pwr_good(pwr_good),
        .reg_wr_en(wr_en), .reg_wr_addr(wr_addr), .reg_wr_data(wr_data),
        .reg_rd_req(rd_req), .reg_rd_addr(rd_addr), .reg_rd_data(rd_data),
        .err_recovery(err_rec), .err_addr_change(err_addr)
    );

    // Register file model
    logic [DW-1:0] mem [16];
    int            wr_cnt;
    logic [AW-1:0] last_wa;
    logic [DW-1:0] last_wd;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mem[i] <= '0;
            wr_cnt  <= 0;
            last_wa <= '0;
            last_wd <= '0;
            rd_data <= '0;
        end else begin
            if (wr_en) begin
                mem[wr_addr[3:0]] <= wr_data;
                wr_cnt  <= wr_cnt + 1;
                last_wa <= wr_addr;
                last_wd <= wr_data;
            end
            if (rd_req) rd_data <= mem[rd_addr[3:0]];
        end
    end

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int base;
    logic [DW-1:0] got;
    logic          en;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit end_by_ce);
        @(negedge clk); bus_addr = a; bus_din = d;
        repeat (2) @(negedge clk); ce_n = 1'b0;
        repeat (3) @(negedge clk); we_n = 1'b0;
        repeat (6) @(negedge clk);
        if (end_by_ce) ce_n = 1'b1; else we_n = 1'b1;
        repeat (3) @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
        repeat (REC + 8) @(negedge clk);
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] g, output logic e);
        @(negedge clk); bus_addr = a;
        repeat (2) @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
        repeat (10) @(negedge clk);
        g = bus_dout; e = bus_dout_en;
        ce_n = 1'b1; oe_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        pwr_good = 1'b1; bus_addr = '0; bus_din = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        check("R10 wr_en",      {31'd0, wr_en},       0);
        check("R10 rd_req",     {31'd0, rd_req},      0);
        check("R10 dout_en",    {31'd0, bus_dout_en}, 0);
        check("R10 err_rec",    {31'd0, err_rec},     0);
        check("R10 err_addr",   {31'd0, err_addr},    0);

        repeat (QUAL + 10) @(negedge clk);

        // Vector walk: R3 writes, R1 reads
        for (int i = 0; i < 8; i++) begin
            if (VEC[i][25]) begin
                base = wr_cnt;
                do_write(VEC[i][24:8], VEC[i][7:0], i[0]);
                check("R3 write pulse count", wr_cnt - base, 1);
                check("R3 write data",  {24'd0, last_wd}, {24'd0, VEC[i][7:0]});
                check("R3 write addr",  {15'd0, last_wa}, {15'd0, VEC[i][24:8]});
            end else begin
                do_read(VEC[i][24:8], got, en);
                check("R1 read data",   {24'd0, got}, {24'd0, VEC[i][7:0]});
                check("R1 drive enable", {31'd0, en}, 1);
            end
        end

        // R2: address change during a read
        @(negedge clk); bus_addr = 17'd3;
        repeat (2) @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
        repeat (10) @(negedge clk);
        check("R2 first address", {24'd0, bus_dout}, 32'hA5);
        bus_addr = 17'd5;
        repeat (10) @(negedge clk);
        check("R2 followed address", {24'd0, bus_dout}, 32'h3C);
        check("R2 still driving", {31'd0, bus_dout_en}, 1);
        ce_n = 1'b1; oe_n = 1'b1;
        repeat (6) @(negedge clk);

        // R3: data changed late in the cycle, last sample wins
        base = wr_cnt;
        @(negedge clk); bus_addr = 17'd2; bus_din = 8'h10;
        repeat (2) @(negedge clk); ce_n = 1'b0;
        repeat (3) @(negedge clk); we_n = 1'b0;
        repeat (3) @(negedge clk); bus_din = 8'h42;
        repeat (4) @(negedge clk); we_n = 1'b1; ce_n = 1'b1;
        repeat (REC + 8) @(negedge clk);
        check("R3 last sample committed", {24'd0, last_wd}, 32'h42);
        check("R3 one pulse", wr_cnt - base, 1);

        // R4: write strobe first, select second
        base = wr_cnt;
        @(negedge clk); bus_addr = 17'd4; bus_din = 8'h99;
        repeat (2) @(negedge clk); we_n = 1'b0;
        repeat (3) @(negedge clk); ce_n = 1'b0;
        repeat (6) @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
        repeat (REC + 8) @(negedge clk);
        check("R4 we-first write", wr_cnt - base, 1);
        check("R4 we-first data", {24'd0, mem[4]}, 32'h99);

        // R4: write strobe alone, select high
        base = wr_cnt;
        @(negedge clk); bus_addr = 17'd4; bus_din = 8'h11;
        repeat (2) @(negedge clk); we_n = 1'b0;
        repeat (6) @(negedge clk); we_n = 1'b1;
        repeat (REC + 8) @(negedge clk);
        check("R4 no write without select", wr_cnt - base, 0);
        do_read(17'd4, got, en);
        check("R4 contents kept", {24'd0, got}, 32'h99);

        // R5: write strobe falls during a driven read
        @(negedge clk); bus_addr = 17'd3; bus_din = 8'hA5;
        repeat (2) @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
        repeat (10) @(negedge clk);
        check("R5 driving before", {31'd0, bus_dout_en}, 1);
        we_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R5 driver released", {31'd0, bus_dout_en}, 0);
        repeat (4) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        repeat (REC + 8) @(negedge clk);
        check("R5 write stored bus value", {24'd0, mem[3]}, 32'hA5);

        // R9: address moves during a write
        check("R9 flag clear before", {31'd0, err_addr}, 0);
        base = wr_cnt;
        @(negedge clk); bus_addr = 17'd10; bus_din = 8'h33;
        repeat (2) @(negedge clk); ce_n = 1'b0;
        repeat (3) @(negedge clk); we_n = 1'b0;
        repeat (3) @(negedge clk); bus_addr = 17'd11;
        repeat (4) @(negedge clk); we_n = 1'b1; ce_n = 1'b1;
        repeat (REC + 8) @(negedge clk);
        check("R9 flag set", {31'd0, err_addr}, 1);
        check("R9 latched address", {15'd0, last_wa}, 32'd10);
        check("R9 one pulse", wr_cnt - base, 1);
        check("R9 moved-to address untouched", {24'd0, mem[11]}, 0);

        // R6: new write inside the recovery window
        check("R6 flag clear before", {31'd0, err_rec}, 0);
        base = wr_cnt;
        @(negedge clk); bus_addr = 17'd6; bus_din = 8'h11;
        repeat (2) @(negedge clk); ce_n = 1'b0;
        repeat (3) @(negedge clk); we_n = 1'b0;
        repeat (6) @(negedge clk); we_n = 1'b1;
        repeat (2) @(negedge clk); bus_addr = 17'd7; bus_din = 8'h22; we_n = 1'b0;
        repeat (6) @(negedge clk); we_n = 1'b1; ce_n = 1'b1;
        repeat (REC + 8) @(negedge clk);
        check("R6 flag set", {31'd0, err_rec}, 1);
        check("R6 only first write", wr_cnt - base, 1);
        check("R6 first data", {24'd0, mem[6]}, 32'h11);
        do_read(17'd7, got, en);
        check("R6 rejected write absent", {24'd0, got}, 0);

        // R7: power not good
        @(negedge clk); pwr_good = 1'b0;
        repeat (5) @(negedge clk);
        base = wr_cnt;
        do_write(17'd3, 8'h77, 1'b0);
        check("R7 no pulse while down", wr_cnt - base, 0);

        // R8: inside the qualification window
        pwr_good = 1'b1;
        do_write(17'd3, 8'h66, 1'b0);
        check("R8 blocked while qualifying", wr_cnt - base, 0);
        repeat (QUAL + 10) @(negedge clk);
        do_read(17'd3, got, en);
        check("R7 contents unchanged", {24'd0, got}, 32'hA5);
        do_write(17'd3, 8'h5A, 1'b1);
        check("R8 write after qualification", wr_cnt - base, 1);
        do_read(17'd3, got, en);
        check("R8 new contents", {24'd0, got}, 32'h5A);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule